// File: doc/BRIEF.md
# Serial-Memory Two-Wire Slave Front End

This block is the bus-facing half of a small serial memory. It watches the two I2C lines with a fast system clock, finds START and STOP conditions, and takes in an address byte. It acknowledges only when the address byte carries the fixed device-type prefix and the three board-strapped select bits. Once selected, it either takes write bytes from the master and hands each one to the memory side with a one-cycle strobe, or fetches bytes from the memory side and shifts them out to the master. It keeps doing this until the master declines a byte, issues a STOP, or restarts.

The memory side sees a plain byte handshake. `wr_stb` with `wr_data` delivers each byte that was received. `rd_req` tells the memory that the byte on `rd_data` has been taken, so it may move on to the next one. A write-protect pin holds back every write strobe, but the bus transfer is still acknowledged, so the master sees a normal transaction. The block never drives the data line high. `sda_oe` high means "pull SDA low", and a released line reads as 1.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset and until a START is seen, clocked bus traffic produces no acknowledge, no `wr_stb` and no `rd_req`.
- R2: The address byte is the first byte after a START, sent MSB first. When its upper four bits equal 4'b1010 and bits 3..1 equal `strap_i[2:0]`, the block holds SDA low for the whole 9th clock.
- R3: When the address byte does not match, the block gives no acknowledge and ignores all further bytes until the next START.
- R4: After a matching address with bit 0 = 0 (write), each following byte is received MSB first. It is acknowledged on its 9th clock and appears on `wr_data` together with a `wr_stb` pulse exactly one cycle long.
- R5: While `wp_i` is high, no `wr_stb` is issued, but the address and data bytes are still acknowledged.
- R6: After a matching address with bit 0 = 1 (read), the block takes `rd_data` at the falling SCL edge that ends the acknowledge clock and pulses `rd_req` for one cycle. It then shifts the byte out MSB first, changing SDA only while SCL is low.
- R7: During a read, a master acknowledge (SDA low on the 9th clock) makes the block fetch and send the next byte. A not-acknowledge ends the read: SDA stays released and there is no further `rd_req` until a START.
- R8: A STOP at any point ends the transaction and releases SDA. Later clocks without a START are ignored.
- R9: A repeated START during a transaction restarts address reception, so a read can directly follow a write.
- R10: During reset, and after it, `sda_oe`, `wr_stb` and `rd_req` are low until bus activity calls for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| strap_i | input | 3 | Board-strapped device select bits |
| wp_i | input | 1 | Write protect, high blocks write strobes |
| wr_stb | output | 1 | One-cycle strobe for a received byte |
| wr_data | output | 8 | Received byte, valid with `wr_stb` |
| rd_data | input | 8 | Byte the memory offers for the next read |
| rd_req | output | 1 | One-cycle pulse after `rd_data` was taken |

## Verification
The bench goes after address decoding. It checks both a wrong device-type prefix and a wrong strap value. A decoder that compared too few bits would acknowledge a foreign device. It checks that write protect removes the strobe but keeps the acknowledge, so a block that dropped the acknowledge would show up as a missing ACK. It reads two bytes and ends with a not-acknowledge, then clocks one more byte. A block that ignored the master's reply would keep driving SDA and issuing `rd_req`. A STOP in the middle of a byte and a repeated START from write into read are also tested, since a block that latched stale state would strobe a partial byte or miss the new address.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    localparam logic [3:0] DEV_TYPE_DEF = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_ACK_SET,
        ST_ACK_HOLD,
        ST_RDATA,
        ST_MACK,
        ST_MACK_END,
        ST_WAIT
    } bus_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic prv
);
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], din};
    end

    // Idle bus lines are high, so reset to ones to avoid a false edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign lvl = chain_q[STAGES-1];
    assign prv = chain_q[STAGES];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic scl_lvl,
    input  logic scl_prv,
    input  logic sda_lvl,
    input  logic sda_prv,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt,
    output logic sda_bit
);
    logic scl_high;

    always_comb begin
        scl_high  = scl_lvl & scl_prv;
        scl_rise  = scl_lvl & ~scl_prv;
        scl_fall  = ~scl_lvl & scl_prv;
        start_evt = scl_high & sda_prv & ~sda_lvl;
        stop_evt  = scl_high & ~sda_prv & sda_lvl;
        sda_bit   = sda_lvl;
    end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int STRAP_W     = 3,
    parameter int SYNC_STAGES = 2,
    parameter logic [DATA_W-STRAP_W-2:0] DEV_TYPE = DEV_TYPE_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic              wp_i,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req
);
    localparam int TYPE_W = DATA_W - STRAP_W - 1;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int LINES  = 2;

    typedef struct packed {
        bus_state_e        st;
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              rd_mode;
        logic              ack_ok;
        logic              oe;
        logic              wstb;
        logic [DATA_W-1:0] wdat;
        logic              rreq;
    } regs_t;

    regs_t r_d, r_q;

    // Line synchronizers: index 0 = SCL, index 1 = SDA
    logic [LINES-1:0] raw, lvl, prv;
    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[g]),
            .lvl  (lvl[g]),
            .prv  (prv[g])
        );
    end

    logic scl_rise, scl_fall, start_evt, stop_evt, sda_bit;

    i2c_bus_events u_events (
        .scl_lvl  (lvl[0]),
        .scl_prv  (prv[0]),
        .sda_lvl  (lvl[1]),
        .sda_prv  (prv[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .sda_bit  (sda_bit)
    );

    logic [DATA_W-1:0] next_byte;
    logic              addr_hit;
    logic              byte_done;

    always_comb begin
        next_byte = {r_q.sh[DATA_W-2:0], sda_bit};
        addr_hit  = (next_byte[DATA_W-1 -: TYPE_W] == DEV_TYPE) &&
                    (next_byte[STRAP_W:1] == strap_i);
        byte_done = (r_q.cnt == CNT_W'(DATA_W - 1));
    end

    always_comb begin
        r_d      = r_q;
        r_d.wstb = 1'b0;
        r_d.rreq = 1'b0;

        if (stop_evt) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else if (start_evt) begin
            r_d.st  = ST_ADDR;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        r_d.sh  = next_byte;
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (byte_done) begin
                            r_d.st = ST_ACK_SET;
                            if (r_q.st == ST_ADDR) begin
                                r_d.ack_ok  = addr_hit;
                                r_d.rd_mode = next_byte[0];
                            end else begin
                                r_d.ack_ok = 1'b1;
                                r_d.wdat   = next_byte;
                                r_d.wstb   = ~wp_i;
                            end
                        end
                    end
                end
                ST_ACK_SET: begin
                    if (scl_fall) begin
                        if (r_q.ack_ok) begin
                            r_d.oe = 1'b1;
                            r_d.st = ST_ACK_HOLD;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                ST_ACK_HOLD, ST_MACK_END: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.rd_mode) begin
                            r_d.sh   = rd_data;
                            r_d.oe   = ~rd_data[DATA_W-1];
                            r_d.rreq = 1'b1;
                            r_d.st   = ST_RDATA;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.cnt == CNT_W'(DATA_W)) begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_MACK;
                        end else begin
                            r_d.sh = r_q.sh << 1;
                            r_d.oe = ~r_q.sh[DATA_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        r_d.st = sda_bit ? ST_WAIT : ST_MACK_END;
                    end
                end
                default: begin
                    // ST_IDLE and ST_WAIT: only START or STOP leave here
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, sh: '0, cnt: '0, rd_mode: 1'b0, ack_ok: 1'b0,
                     oe: 1'b0, wstb: 1'b0, wdat: '0, rreq: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe  = r_q.oe;
    assign wr_stb  = r_q.wstb;
    assign wr_data = r_q.wdat;
    assign rd_req  = r_q.rreq;
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic wp_i,
    input logic sda_oe,
    input logic wr_stb,
    input logic rd_req
);
    // R5: a strobe never follows a cycle where write protect was high
    a_r5_wp_blocks_stb: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !$past(wp_i));

    // R4: write strobe lasts exactly one cycle
    a_r4_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R6: read fetch request lasts exactly one cycle
    a_r6_rreq_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R6: SDA is only pulled low while SCL is low
    a_r6_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R10: write and read handshakes never coincide
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_req));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .wp_i  (wp_i),
    .sda_oe(sda_oe),
    .wr_stb(wr_stb),
    .rd_req(rd_req)
);

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
    localparam int H2 = 10;   // quarter SCL period in clk cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b000;   // default tie-off low
    logic       wp = 1'b0;        // default tie-off low
    logic       sda_oe, wr_stb, rd_req;
    logic [7:0] wr_data, rd_data;
    logic       sda_bus;

    int checks = 0;
    int fails = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [7:0] wr_last = '0;
    int  rd_idx = 0;
    bit  done = 0;

    always #2 clk = ~clk;   // 250 MHz

    assign sda_bus = sda_m & ~sda_oe;

    function automatic logic [7:0] mem_byte(input int idx);
        logic [3:0] n;
        n = idx[3:0];
        return {n, ~n} ^ 8'h5A;
    endfunction

    assign rd_data = mem_byte(rd_idx);

    i2c_mem_slave dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe),
        .strap_i(strap),
        .wp_i   (wp),
        .wr_stb (wr_stb),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .rd_req (rd_req)
    );

    always @(negedge clk) begin
        if (wr_stb) begin
            wr_cnt  <= wr_cnt + 1;
            wr_last <= wr_data;
        end
        if (rd_req) begin
            rd_cnt <= rd_cnt + 1;
            rd_idx <= rd_idx + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, output logic s);
        sda_m = b;
        wait_clk(H2);
        scl = 1'b1;
        wait_clk(H2);
        s = sda_bus;
        wait_clk(H2);
        scl = 1'b0;
        wait_clk(H2);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(H2);
        scl = 1'b1;   wait_clk(H2);
        sda_m = 1'b0; wait_clk(H2);
        scl = 1'b0;   wait_clk(H2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(H2);
        scl = 1'b1;   wait_clk(H2);
        sda_m = 1'b1; wait_clk(H2);
    endtask

    task automatic scl_low();
        scl = 1'b0;
        wait_clk(H2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(b[i], s);
        send_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, s);
            v[i] = s;
        end
        send_bit(mack, s);
    endtask

    // Vector: [21:19] strap, [18:11] address, [10:3] data, [2] wp,
    //         [1] expected ACK on both bytes, [0] expected strobe
    localparam int NVEC = 6;
    localparam logic [21:0] VEC [NVEC] = '{
        {3'b000, 8'hA0, 8'h3C, 1'b0, 1'b1, 1'b1},
        {3'b101, 8'hAA, 8'hC5, 1'b0, 1'b1, 1'b1},
        {3'b101, 8'hA0, 8'h5A, 1'b0, 1'b0, 1'b0},
        {3'b000, 8'hB0, 8'h77, 1'b0, 1'b0, 1'b0},
        {3'b011, 8'hA6, 8'h81, 1'b1, 1'b1, 1'b0},
        {3'b111, 8'hAE, 8'h00, 1'b0, 1'b1, 1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic       ack, ack2;
        logic [7:0] v;
        int         w0, r0;

        wait_clk(5);
        // R10: reset state
        check(sda_oe == 1'b0, "R10 sda_oe in reset", sda_oe, 0);
        check(wr_stb == 1'b0, "R10 wr_stb in reset", wr_stb, 0);
        check(rd_req == 1'b0, "R10 rd_req in reset", rd_req, 0);
        rst_n = 1'b1;
        wait_clk(5);
        check(sda_oe == 1'b0, "R10 sda_oe after reset", sda_oe, 0);

        // R1: traffic before any START is ignored
        scl_low();
        send_byte(8'hA0, ack);
        send_byte(8'h12, ack2);
        check(ack == 1'b0, "R1 no ack before start", ack, 0);
        check(ack2 == 1'b0, "R1 no data ack before start", ack2, 0);
        check(wr_cnt == 0, "R1 no strobe before start", wr_cnt, 0);
        sda_m = 1'b1; wait_clk(H2);
        scl = 1'b1;   wait_clk(H2);

        // Vector walk: R2, R3, R4, R5
        for (int k = 0; k < NVEC; k++) begin
            strap = VEC[k][21:19];
            wp    = VEC[k][2];
            w0    = wr_cnt;
            bus_start();
            send_byte(VEC[k][18:11], ack);
            send_byte(VEC[k][10:3], ack2);
            bus_stop();
            wait_clk(4);
            check(ack == VEC[k][1], "R2/R3 address ack", ack, VEC[k][1]);
            check(ack2 == VEC[k][1], "R4/R5 data ack", ack2, VEC[k][1]);
            check((wr_cnt - w0) == int'(VEC[k][0]), "R5 strobe count", wr_cnt - w0, VEC[k][0]);
            if (VEC[k][0])
                check(wr_last == VEC[k][10:3], "R4 write byte", wr_last, VEC[k][10:3]);
        end
        strap = 3'b000;
        wp    = 1'b0;

        // R6 / R7: read two bytes, master ACK then NoACK
        r0 = rd_cnt;
        bus_start();
        send_byte(8'hA1, ack);
        check(ack == 1'b1, "R6 read address ack", ack, 1);
        read_byte(1'b0, v);
        check(v == mem_byte(0), "R6 first read byte", v, mem_byte(0));
        read_byte(1'b1, v);
        check(v == mem_byte(1), "R7 second read byte after ack", v, mem_byte(1));
        read_byte(1'b1, v);
        check(v == 8'hFF, "R7 line released after noack", v, 8'hFF);
        check((rd_cnt - r0) == 2, "R7 fetch count", rd_cnt - r0, 2);
        bus_stop();

        // R8: STOP in mid byte, then clocks without START
        w0 = wr_cnt;
        bus_start();
        send_byte(8'hA0, ack);
        for (int i = 0; i < 4; i++) send_bit(i[0], ack2);
        bus_stop();
        scl_low();
        send_byte(8'hA0, ack);
        send_byte(8'h99, ack2);
        check(ack == 1'b0 && ack2 == 1'b0, "R8 ignored after stop", {ack, ack2}, 0);
        check(wr_cnt == w0, "R8 no strobe after stop", wr_cnt - w0, 0);
        sda_m = 1'b1; wait_clk(H2);
        scl = 1'b1;   wait_clk(H2);

        // R9: write two bytes, repeated START, then read
        w0 = wr_cnt;
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h11, ack2);
        check(wr_last == 8'h11, "R4 first of two bytes", wr_last, 8'h11);
        send_byte(8'hE7, ack2);
        check(ack2 == 1'b1 && wr_last == 8'hE7, "R4 second of two bytes", wr_last, 8'hE7);
        check((wr_cnt - w0) == 2, "R4 two strobes", wr_cnt - w0, 2);
        bus_start();
        send_byte(8'hA1, ack);
        check(ack == 1'b1, "R9 restart address ack", ack, 1);
        read_byte(1'b1, v);
        check(v == mem_byte(2), "R9 read after restart", v, mem_byte(2));
        bus_stop();
        wait_clk(10);
        check(sda_oe == 1'b0, "R8 released at end", sda_oe, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule